// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a 32-bit internal bus through four 64-bit registers. The host writes a data word, then writes a command word. That single command write starts one read or one write on the internal bus. The command carries the direction, the byte count and the target address. When the internal response comes back, the bridge posts a done flag in a status register. For a read, the returned word is placed in the same status register. Reading the status register hands its value to the host and empties it in the same access. Status is therefore a one-shot mailbox.

The internal side holds at most one transaction at a time. A request is offered with valid/ready and held stable until it is taken. The response is a single-cycle pulse carrying data and an error flag. A failed read is reported as a completed read whose data is all ones. A write reports done whether or not the bus flagged an error.

Control flows through a three-state machine:
- **ST_IDLE**: no transaction outstanding.
- **ST_ISSUE**: the request is offered on the internal port.
- **ST_AWAIT**: the request was taken and the response is pending.

The transitions are:
- **launch** (ST_IDLE to ST_ISSUE): a control write with an acceptable size.
- **handoff** (ST_ISSUE to ST_AWAIT): `bus_req_ready` is high while the request is valid.
- **complete** (ST_AWAIT to ST_IDLE): `bus_rsp_valid` pulses and the status is posted.

No other transition exists. Every other input leaves the state unchanged.

Top module: `ind_reg_bridge`

## Requirements
- R1: Host address bits [4:3] select the register: 0 control, 1 reset, 2 status, 3 data.
- R2: A control write in ST_IDLE launches exactly one internal request. Control bit 48 set means a read (`bus_req_write`=0); bit 48 clear means a write (`bus_req_write`=1).
- R3: The request carries control bits [59:56] as `bus_req_size` and control bits [31:0] as `bus_req_addr`.
- R4: A control write with size greater than 8 issues no request and leaves the status register unchanged. A size of exactly 8 is accepted.
- R5: A read whose response has no error posts status bit 11 (done) and places the returned word in status bits [57:26]. Bus byte [31:24] (the first byte received) lands in status [57:50]. All other status bits read zero.
- R6: A read whose response flags an error posts done and sets status bits [57:26] to all ones.
- R7: A write sends the data register on `bus_req_wdata`, with its most significant byte [31:24] as the first byte. On completion it posts done with a zero data field, whether or not the error flag is set.
- R8: A status read returns the current status value and clears the register to zero at that same access.
- R9: A data register write stores host bits [63:32]. A data register read returns the stored word in bits [63:32] and zeros in bits [31:0].
- R10: Control and reset registers read as zero. Writes to the reset and status registers change nothing, and a reset write launches no request.
- R11: While a transaction is outstanding, further control writes are ignored. The status register reads zero from the launch until the response arrives.
- R12: An offered request stays valid, with stable address, size and direction, until it is taken. It drops after the handoff.
- R13: If a status read falls in the same cycle as a response, the read returns the pre-post value and the newly posted value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | HOST_AW | Host byte address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, valid in the cycle `host_re` is high |
| bus_req_valid | output | 1 | Internal request offered |
| bus_req_ready | input | 1 | Internal request taken |
| bus_req_write | output | 1 | 1 for a write, 0 for a read |
| bus_req_addr | output | 32 | Internal target address |
| bus_req_size | output | 4 | Byte count of the transfer |
| bus_req_wdata | output | 32 | Write data, first byte in [31:24] |
| bus_rsp_valid | input | 1 | Single-cycle response pulse |
| bus_rsp_err | input | 1 | Response error flag |
| bus_rsp_rdata | input | 32 | Read data, first byte in [31:24] |

## Verification
Clear-on-read and response posting both write the status register, so they can land in the same cycle. The bench provokes this by raising `host_re` on the status address in the very cycle it pulses `bus_rsp_valid`. It then checks two things: that the read returned zero (the outstanding-transaction value), and that a second read returns the full posted word. A second overlap is a control write arriving while a request is still being offered. The bench judges that case by holding `bus_req_ready` low and confirming that the address on the port does not move.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;
    localparam int BUS_AW        = 32;
    localparam int BUS_DW        = 32;
    localparam int SZ_W          = 4;
    localparam int HOST_DW       = 64;
    localparam int SEL_LSB       = 3;
    localparam int CMD_RD_BIT    = 48;
    localparam int CMD_SZ_LSB    = 56;
    localparam int STAT_DONE_BIT = 11;
    localparam int STAT_DATA_LSB = 26;
    localparam int DATA_LSB      = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } xact_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              is_rd;
        logic [SZ_W-1:0]   size;
        logic [BUS_AW-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/ibr_host_decode.sv
`timescale 1ns/1ps
module ibr_host_decode
    import ibr_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic [HOST_DW-1:0] stat_word,
    output logic               cmd_strobe,
    output cmd_t               cmd,
    output logic               stat_rd,
    output logic [BUS_DW-1:0]  data_q
);
    reg_sel_e sel;
    logic     unused_addr_bits;

    assign sel              = reg_sel_e'(host_addr[SEL_LSB+1:SEL_LSB]);
    assign unused_addr_bits = ^{host_addr};

    assign cmd_strobe = host_we && (sel == SEL_CTRL);
    assign stat_rd    = host_re && (sel == SEL_STAT);
    assign cmd.is_rd  = host_wdata[CMD_RD_BIT];
    assign cmd.size   = host_wdata[CMD_SZ_LSB +: SZ_W];
    assign cmd.addr   = host_wdata[BUS_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (host_we && (sel == SEL_DATA)) begin
            data_q <= host_wdata[DATA_LSB +: BUS_DW];
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_re) begin
            unique case (sel)
                SEL_CTRL, SEL_RST: host_rdata = '0;
                SEL_STAT:          host_rdata = stat_word;
                SEL_DATA:          host_rdata = {data_q, {DATA_LSB{1'b0}}};
                default:           host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ibr_xact_fsm.sv
`timescale 1ns/1ps
module ibr_xact_fsm
    import ibr_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_strobe,
    input  cmd_t              cmd,
    input  logic [BUS_DW-1:0] data_q,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [BUS_AW-1:0] bus_req_addr,
    output logic [SZ_W-1:0]   bus_req_size,
    output logic [BUS_DW-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err,
    input  logic [BUS_DW-1:0] bus_rsp_rdata,
    output logic              accept,
    output logic              busy,
    output logic              post,
    output logic              post_rd,
    output logic              post_err,
    output logic [BUS_DW-1:0] post_data
);
    localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(MAX_BYTES);

    xact_state_e       state, state_n;
    cmd_t              lat_cmd;
    logic [BUS_DW-1:0] lat_wdata;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cmd   <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_cmd   <= cmd;
            lat_wdata <= data_q;
        end
    end

    always_comb begin
        state_n       = state;
        accept        = 1'b0;
        post          = 1'b0;
        bus_req_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_strobe && (cmd.size <= MAX_SZ)) begin
                    accept  = 1'b1;
                    state_n = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                bus_req_valid = 1'b1;
                if (bus_req_ready) state_n = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (bus_rsp_valid) begin
                    post    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign busy          = (state != ST_IDLE);
    assign bus_req_write = ~lat_cmd.is_rd;
    assign bus_req_addr  = lat_cmd.addr;
    assign bus_req_size  = lat_cmd.size;
    assign bus_req_wdata = lat_wdata;
    assign post_rd       = lat_cmd.is_rd;
    assign post_err      = bus_rsp_err;
    assign post_data     = bus_rsp_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
            && $stable(bus_req_size) && $stable(bus_req_write)) else $error("req hold"); // R12
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && bus_req_ready |=> !bus_req_valid) else $error("req drop"); // R12
    AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> bus_req_size <= MAX_SZ) else $error("size limit"); // R4
endmodule

// File: rtl/ibr_status.sv
`timescale 1ns/1ps
module ibr_status
    import ibr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               stat_rd,
    input  logic               post,
    input  logic               post_rd,
    input  logic               post_err,
    input  logic [BUS_DW-1:0]  post_data,
    output logic [HOST_DW-1:0] stat_word
);
    logic              done_q;
    logic [BUS_DW-1:0] sdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            sdata_q <= '0;
        end else if (post) begin
            done_q <= 1'b1;
            if (!post_rd)      sdata_q <= '0;
            else if (post_err) sdata_q <= '1;
            else               sdata_q <= post_data;
        end else if (stat_rd || accept) begin
            done_q  <= 1'b0;
            sdata_q <= '0;
        end
    end

    assign stat_word = (HOST_DW'(sdata_q) << STAT_DATA_LSB)
                     | (HOST_DW'(done_q) << STAT_DONE_BIT);

    AST_POST_DONE: assert property (@(posedge clk) disable iff (rst)
        post |=> done_q) else $error("post done"); // R5
    AST_FAIL_ONES: assert property (@(posedge clk) disable iff (rst)
        post && post_rd && post_err |=> sdata_q == '1) else $error("fail ones"); // R6
    AST_CLEAR_READ: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !post |=> !done_q && sdata_q == '0) else $error("clear on read"); // R8
endmodule

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int HOST_AW   = 5,
    parameter int MAX_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [63:0]        host_wdata,
    output logic [63:0]        host_rdata,
    output logic               bus_req_valid,
    input  logic               bus_req_ready,
    output logic               bus_req_write,
    output logic [31:0]        bus_req_addr,
    output logic [3:0]         bus_req_size,
    output logic [31:0]        bus_req_wdata,
    input  logic               bus_rsp_valid,
    input  logic               bus_rsp_err,
    input  logic [31:0]        bus_rsp_rdata
);
    logic               cmd_strobe, stat_rd, accept, busy;
    logic               post, post_rd, post_err;
    cmd_t               cmd;
    logic [BUS_DW-1:0]  data_q, post_data;
    logic [HOST_DW-1:0] stat_word;

    ibr_host_decode #(.HOST_AW(HOST_AW)) u_dec (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .stat_word(stat_word), .cmd_strobe(cmd_strobe), .cmd(cmd),
        .stat_rd(stat_rd), .data_q(data_q)
    );

    ibr_xact_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk(clk), .rst(rst), .cmd_strobe(cmd_strobe), .cmd(cmd), .data_q(data_q),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata), .accept(accept), .busy(busy),
        .post(post), .post_rd(post_rd), .post_err(post_err), .post_data(post_data)
    );

    ibr_status u_stat (
        .clk(clk), .rst(rst), .accept(accept), .stat_rd(stat_rd), .post(post),
        .post_rd(post_rd), .post_err(post_err), .post_data(post_data),
        .stat_word(stat_word)
    );

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> stat_word == '0) else $error("status not quiet"); // R11
    AST_IGNORE_BUSY_CMD: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_strobe |-> !accept) else $error("busy accept"); // R11
endmodule

// File: tb/sim_ind_reg_bridge.sv
`timescale 1ns/1ps
module sim_ind_reg_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 0, host_re = 0;
    logic [4:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        bus_req_valid, bus_req_write;
    logic        bus_req_ready = 0;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic [3:0]  bus_req_size;
    logic        bus_rsp_valid = 0, bus_rsp_err = 0;
    logic [31:0] bus_rsp_rdata = '0;

    int total = 0;
    int bad   = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;

    always #2 clk = ~clk;

    ind_reg_bridge u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ctl(bit rd, int sz, logic [31:0] a);
        logic [63:0] w = '0;
        w[48]    = rd;
        w[59:56] = sz[3:0];
        w[31:0]  = a;
        return w;
    endfunction

    function automatic logic [63:0] st_word(bit done, logic [31:0] d);
        return (64'(d) << 26) | (64'(done) << 11);
    endfunction

    task automatic host_write(logic [4:0] a, logic [63:0] d);
        @(posedge clk); #0.5;
        host_we = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #0.5;
        host_we = 0;
    endtask

    task automatic host_read(logic [4:0] a, output logic [63:0] v);
        @(posedge clk); #0.5;
        host_re = 1; host_addr = a;
        #2 v = host_rdata;
        @(posedge clk); #0.5;
        host_re = 0;
    endtask

    task automatic serve(int delay, bit err, logic [31:0] rd);
        logic [31:0] a0 = bus_req_addr;
        for (int i = 0; i < delay; i++) begin
            @(posedge clk); #0.5;
            check("R12 hold valid", 64'(bus_req_valid), 64'd1);
            check("R12 hold addr", 64'(bus_req_addr), 64'(a0));
        end
        bus_req_ready = 1;
        @(posedge clk); #0.5;
        bus_req_ready = 0;
        check("R12 drop after handoff", 64'(bus_req_valid), 64'd0);
        bus_rsp_valid = 1; bus_rsp_err = err; bus_rsp_rdata = rd;
        @(posedge clk); #0.5;
        bus_rsp_valid = 0; bus_rsp_err = 0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R2 idle after reset", 64'(bus_req_valid), 64'd0);
        host_read(A_STAT, v); check("R8 status after reset", v, 64'd0);
        host_read(A_DATA, v); check("R9 data after reset", v, 64'd0);
    endtask

    task automatic t_data_reg();
        logic [63:0] v;
        host_write(A_DATA, 64'hA1B2C3D4_55667788);
        host_read(A_DATA, v); check("R9 data readback", v, 64'hA1B2C3D4_00000000);
    endtask

    task automatic t_ctrl_rst();
        logic [63:0] v;
        host_read(A_CTRL, v); check("R10 control reads zero", v, 64'd0);
        host_write(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 reset write launches nothing", 64'(bus_req_valid), 64'd0);
        host_read(A_RST, v); check("R10 reset reads zero", v, 64'd0);
        host_read(A_DATA, v); check("R1 decode keeps data", v, 64'hA1B2C3D4_00000000);
    endtask

    task automatic t_read_ok();
        logic [63:0] v;
        host_write(A_CTRL, ctl(1, 4, 32'hC001_2038));
        check("R2 read launches", 64'(bus_req_valid), 64'd1);
        check("R2 direction read", 64'(bus_req_write), 64'd0);
        check("R3 addr", 64'(bus_req_addr), 64'hC001_2038);
        check("R3 size", 64'(bus_req_size), 64'd4);
        serve(2, 0, 32'h1122_3344);
        host_read(A_STAT, v); check("R5 read posted", v, st_word(1, 32'h1122_3344));
        host_read(A_STAT, v); check("R8 cleared by read", v, 64'd0);
    endtask

    task automatic t_read_err();
        logic [63:0] v;
        host_write(A_CTRL, ctl(1, 1, 32'h0000_0010));
        serve(0, 1, 32'h0000_0000);
        host_read(A_STAT, v); check("R6 failed read ones", v, st_word(1, 32'hFFFF_FFFF));
    endtask

    task automatic t_write_and_bad_size();
        logic [63:0] v;
        host_write(A_DATA, 64'hDEADBEEF_00000000);
        host_write(A_CTRL, ctl(0, 4, 32'hD001_0060));
        check("R2 direction write", 64'(bus_req_write), 64'd1);
        check("R7 write data order", 64'(bus_req_wdata), 64'hDEADBEEF);
        serve(1, 1, 32'h5555_5555);
        host_write(A_CTRL, ctl(0, 9, 32'h0000_0044));
        check("R4 size 9 rejected", 64'(bus_req_valid), 64'd0);
        host_write(A_CTRL, ctl(1, 15, 32'h0000_0048));
        check("R4 size 15 rejected", 64'(bus_req_valid), 64'd0);
        host_write(A_STAT, 64'd0);
        host_write(A_RST, 64'd0);
        host_read(A_STAT, v); check("R7 write done despite error; R4/R10 status kept", v, st_word(1, 32'd0));
    endtask

    task automatic t_busy();
        logic [63:0] v;
        host_write(A_CTRL, ctl(1, 8, 32'h0000_1000));
        check("R4 size 8 accepted", 64'(bus_req_valid), 64'd1);
        host_write(A_CTRL, ctl(0, 2, 32'h0000_2000));
        check("R11 busy control ignored addr", 64'(bus_req_addr), 64'h1000);
        check("R11 busy control ignored dir", 64'(bus_req_write), 64'd0);
        host_read(A_STAT, v); check("R11 status zero while busy", v, 64'd0);
        serve(1, 0, 32'h0102_0304);
        check("R11 no second request", 64'(bus_req_valid), 64'd0);
        host_read(A_STAT, v); check("R5 byte placement", v[57:50], 64'h01);
    endtask

    task automatic t_collision();
        logic [63:0] v;
        host_write(A_CTRL, ctl(1, 4, 32'h0000_3000));
        bus_req_ready = 1;
        @(posedge clk); #0.5;
        bus_req_ready = 0;
        bus_rsp_valid = 1; bus_rsp_rdata = 32'hCAFE_F00D;
        host_re = 1; host_addr = A_STAT;
        #2 v = host_rdata;
        check("R13 same-cycle read sees pre-post", v, 64'd0);
        @(posedge clk); #0.5;
        bus_rsp_valid = 0; host_re = 0;
        host_read(A_STAT, v); check("R13 post kept", v, st_word(1, 32'hCAFE_F00D));
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        t_reset();
        t_data_reg();
        t_ctrl_rst();
        t_read_ok();
        t_read_err();
        t_write_and_bad_size();
        t_busy();
        t_collision();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule